// File: doc/BRIEF.md
# Capture/Compare Timer with Pulse Output

This block is a 16-bit up-counter with two channels that each act either as a compare register or as a capture register. An 8-bit control word configures it. The control word selects what happens when the counter overflows. It enables a single pulse pin and sets that pin's asserted polarity. It chooses whether the counter advances on an internal prescaled tick or on edges of an external clock pin. It also enables clearing of the counter on a channel-0 compare hit or on an external clear pin.

Software writes the control word, the channel registers and a run bit through plain write strobes, and it reads them back on dedicated outputs. The external clock, clear and capture pins are asynchronous. Each one passes through a two-flop synchronizer and an edge detector before it reaches the counter logic. The counter advances only when the run bit is set and the counter is not parked after an overflow. The pulse pin is a set/reset output: a channel-0 compare hit asserts it and a channel-1 compare hit deasserts it.

Top module: `cc_timer`

## Requirements
- R1: After reset, `ctrl_o` reads 0x20, `run_o` is 0, `count_o` is 0, both capture flags are 0 and `pulse_o` is 0, which is the inactive level for an active-high output.
- R2: Control bit 7 (overflow stop) at 0: a tick at count 0xFFFF gives 0x0000, and counting carries on from there.
- R3: Control bit 7 at 1: a tick at count 0xFFFF gives 0x0000, and the counter then ignores ticks. `run_o` stays 1 during this time. Writing 1 to the run bit makes the counter advance again from the next tick.
- R4: Control bit 4 at 0 makes the counter advance on `tick_i`. At 1 it advances on synchronized edges of `ext_clk_i` instead, and `tick_i` is ignored. `ext_edge_i` selects the edges: bit 0 = rising, bit 1 = falling, 00 = none, 11 = both.
- R5: Control bit 6 (output enable) at 0 holds `pulse_o` at the inactive level, and compare hits are ignored. When the output is enabled, `pulse_o` shows the inactive level until the first hit.
- R6: With both channels in compare mode, an advance while count equals channel 0 drives the output active, and an advance while count equals channel 1 drives it inactive. When both hit on the same advance, the output goes inactive.
- R7: Control bit 5 sets the polarity: 1 = active high, 0 = active low (inactive level is 1).
- R8: Control bit 3 (compare clear) at 1, with channel 0 in compare mode: an advance while count equals channel 0 sets the counter to 0.
- R9: Control bit 2 at 1: a synchronized rising edge on `ext_clr_i` sets the counter to 0, with priority over an advance, and counting continues afterwards.
- R10: Control bits 0 and 1 give the mode of channel 0 and channel 1 (1 = compare, 0 = capture). On a synchronized rising edge of `cap_trig_i[n]`, a channel in capture mode latches the count value from before that cycle's advance. It also raises `cap_flag_o[n]` for exactly one cycle.
- R11: While either channel is in capture mode, `pulse_o` does not change on compare hits.
- R12: A write to the control word is read back on `ctrl_o`. A write to channel n through `cc_we_i[n]` is read back on `cc0_o` or `cc1_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 8 | Control word write data |
| ctrl_o | output | 8 | Control word readback |
| run_we_i | input | 1 | Run bit write strobe |
| run_wdata_i | input | 1 | Run bit write data |
| run_o | output | 1 | Run bit readback |
| cc_we_i | input | 2 | Channel register write strobes |
| cc_wdata_i | input | 16 | Channel register write data |
| cc0_o | output | 16 | Channel 0 register |
| cc1_o | output | 16 | Channel 1 register |
| tick_i | input | 1 | Internal prescaled count tick |
| ext_clk_i | input | 1 | External count clock (asynchronous) |
| ext_edge_i | input | 2 | External clock edge select |
| ext_clr_i | input | 1 | External clear (asynchronous) |
| cap_trig_i | input | 2 | Capture triggers (asynchronous) |
| count_o | output | 16 | Counter value |
| cap_flag_o | output | 2 | One-cycle capture flags |
| pulse_o | output | 1 | Pulse output pin |

## Verification
The hardest state to reach is the overflow boundary. It takes 65536 advances to arrive there, and the bench has no way to load the counter. The bench holds the tick high for a full count period, once with overflow stop off and once with it on. This confirms the wrap, then the parked state, the run bit still reading 1, and the restart on a run write. The pulse output is checked against a per-cycle model while compare values, polarity, enable, compare clear and tick patterns come from a seeded random generator.

// File: rtl/cct_pkg.sv
package cct_pkg;
  typedef struct packed {
    logic ovf_stop;
    logic out_en;
    logic act_hi;
    logic ext_src;
    logic cmp_clr;
    logic ext_clr;
    logic mode1;
    logic mode0;
  } ctrl_t;

  localparam logic [7:0] CTRL_RST = 8'h20;
endpackage

// File: rtl/cct_sync.sv
module cct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_we_i,
  input  logic         run_wdata_i,
  input  logic         tick_i,
  input  logic         ovf_stop_i,
  input  logic         cmp_clr_i,
  input  logic         hit0_i,
  input  logic         clr_evt_i,
  output logic         adv_o,
  output logic         run_o,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;
  logic run_q, stop_q, cmp_hit, at_max;

  assign adv_o   = run_q & ~stop_q & tick_i;
  assign cmp_hit = cmp_clr_i & hit0_i;
  assign at_max  = (cnt_q == {W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      if (run_we_i) begin
        run_q <= run_wdata_i;
        if (run_wdata_i) stop_q <= 1'b0;
      end
      if (clr_evt_i) cnt_q <= '0;
      else if (adv_o) begin
        if (cmp_hit) cnt_q <= '0;
        else if (at_max) begin
          cnt_q <= '0;
          if (ovf_stop_i) stop_q <= 1'b1;
        end else cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign run_o = run_q;
  assign cnt_o = cnt_q;

  AST_WRAP_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_o && !clr_evt_i && !cmp_hit && at_max && !ovf_stop_i) |=> (cnt_q == '0 && !stop_q)); // R2
  AST_PARK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_q |-> (cnt_q == '0 && !adv_o)); // R3
  AST_PARK_RUN_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_q) |-> run_q); // R3
  AST_EXT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_evt_i |=> (cnt_q == '0)); // R9
  AST_CMP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_o && cmp_hit) |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/cct_channel.sv
module cct_channel #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmp_mode_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         trig_i,
  input  logic         adv_i,
  input  logic [W-1:0] cnt_i,
  output logic         hit_o,
  output logic         flag_o,
  output logic [W-1:0] val_o
);
  logic [W-1:0] val_q;
  logic flag_q, cap_evt;

  assign cap_evt = ~cmp_mode_i & trig_i;
  assign hit_o   = cmp_mode_i & adv_i & (cnt_i == val_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      flag_q <= cap_evt;
      if (we_i)         val_q <= wdata_i;
      else if (cap_evt) val_q <= cnt_i;
    end
  end

  assign flag_o = flag_q;
  assign val_o  = val_q;

  AST_CAP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |=> !flag_q); // R10
  AST_CAP_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt && !we_i) |=> (val_q == $past(cnt_i))); // R10
endmodule

// File: rtl/cct_pulse.sv
module cct_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic out_en_i,
  input  logic freeze_i,
  input  logic act_hi_i,
  input  logic set_i,
  input  logic reset_i,
  output logic pulse_o
);
  logic act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            act_q <= 1'b0;
    else if (!out_en_i)     act_q <= 1'b0;
    else if (!freeze_i) begin
      if (reset_i)          act_q <= 1'b0;  // channel 1 wins
      else if (set_i)       act_q <= 1'b1;
    end
  end

  assign pulse_o = act_hi_i ? act_q : ~act_q;

  AST_OFF_INACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |=> !act_q); // R5
  AST_RESET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en_i && !freeze_i && reset_i) |=> !act_q); // R6
  AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en_i && freeze_i) |=> $stable(act_q)); // R11
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cct_pkg::*;
#(
  parameter int W  = 16,
  parameter int NCH = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ctrl_we_i,
  input  logic [7:0]     ctrl_wdata_i,
  output logic [7:0]     ctrl_o,
  input  logic           run_we_i,
  input  logic           run_wdata_i,
  output logic           run_o,
  input  logic [NCH-1:0] cc_we_i,
  input  logic [W-1:0]   cc_wdata_i,
  output logic [W-1:0]   cc0_o,
  output logic [W-1:0]   cc1_o,
  input  logic           tick_i,
  input  logic           ext_clk_i,
  input  logic [1:0]     ext_edge_i,
  input  logic           ext_clr_i,
  input  logic [NCH-1:0] cap_trig_i,
  output logic [W-1:0]   count_o,
  output logic [NCH-1:0] cap_flag_o,
  output logic           pulse_o
);
  ctrl_t ctrl_q;
  logic ek_rise, ek_fall, clr_rise, clr_fall, ext_evt, tick_sel, adv, clr_evt;
  logic [NCH-1:0] cap_rise, cap_fall, hit, mode;
  logic [W-1:0] cnt;
  logic [W-1:0] ch_val [NCH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= ctrl_t'(CTRL_RST);
    else if (ctrl_we_i) ctrl_q <= ctrl_t'(ctrl_wdata_i);
  end
  assign ctrl_o = ctrl_q;
  assign mode   = {ctrl_q.mode1, ctrl_q.mode0};

  cct_sync u_sync_clk (.clk_i, .rst_ni, .d_i(ext_clk_i), .rise_o(ek_rise),  .fall_o(ek_fall));
  cct_sync u_sync_clr (.clk_i, .rst_ni, .d_i(ext_clr_i), .rise_o(clr_rise), .fall_o(clr_fall));

  assign ext_evt  = (ext_edge_i[0] & ek_rise) | (ext_edge_i[1] & ek_fall);
  assign tick_sel = ctrl_q.ext_src ? ext_evt : tick_i;
  assign clr_evt  = ctrl_q.ext_clr & clr_rise;

  cct_counter #(.W(W)) u_counter (
    .clk_i, .rst_ni,
    .run_we_i, .run_wdata_i,
    .tick_i(tick_sel),
    .ovf_stop_i(ctrl_q.ovf_stop),
    .cmp_clr_i(ctrl_q.cmp_clr),
    .hit0_i(hit[0]),
    .clr_evt_i(clr_evt),
    .adv_o(adv),
    .run_o,
    .cnt_o(cnt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cct_sync u_sync_cap (.clk_i, .rst_ni, .d_i(cap_trig_i[i]), .rise_o(cap_rise[i]), .fall_o(cap_fall[i]));
    cct_channel #(.W(W)) u_ch (
      .clk_i, .rst_ni,
      .cmp_mode_i(mode[i]),
      .we_i(cc_we_i[i]),
      .wdata_i(cc_wdata_i),
      .trig_i(cap_rise[i]),
      .adv_i(adv),
      .cnt_i(cnt),
      .hit_o(hit[i]),
      .flag_o(cap_flag_o[i]),
      .val_o(ch_val[i])
    );
  end

  cct_pulse u_pulse (
    .clk_i, .rst_ni,
    .out_en_i(ctrl_q.out_en),
    .freeze_i(~&mode),
    .act_hi_i(ctrl_q.act_hi),
    .set_i(hit[0]),
    .reset_i(hit[1]),
    .pulse_o
  );

  assign cc0_o   = ch_val[0];
  assign cc1_o   = ch_val[1];
  assign count_o = cnt;

  logic unused_fall;
  assign unused_fall = clr_fall ^ (^cap_fall);

  AST_TICK_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.ext_src && !ext_evt) |-> !adv); // R4
endmodule

// File: tb/cc_timer_bench.sv
`timescale 1ns/1ps
module cc_timer_bench;
  logic clk = 0, rst_n = 0;
  logic ctrl_we = 0; logic [7:0] ctrl_wd = 0; logic [7:0] ctrl_rd;
  logic run_we = 0, run_wd = 0, run_rd;
  logic [1:0] cc_we = 0; logic [15:0] cc_wd = 0, cc0, cc1;
  logic tick = 0, eclk = 0, eclr = 0;
  logic [1:0] eedge = 0, ctrig = 0, cflag;
  logic [15:0] cnt;
  logic pulse;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  cc_timer u_cc_timer (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd), .ctrl_o(ctrl_rd),
    .run_we_i(run_we), .run_wdata_i(run_wd), .run_o(run_rd),
    .cc_we_i(cc_we), .cc_wdata_i(cc_wd), .cc0_o(cc0), .cc1_o(cc1),
    .tick_i(tick), .ext_clk_i(eclk), .ext_edge_i(eedge), .ext_clr_i(eclr),
    .cap_trig_i(ctrig), .count_o(cnt), .cap_flag_o(cflag), .pulse_o(pulse)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic exp_pin(logic act_hi, logic act);
    return act_hi ? act : ~act;
  endfunction

  function automatic logic [15:0] next_cnt(logic [15:0] c, logic adv, logic cclr, logic [15:0] c0);
    if (!adv) return c;
    if (cclr && c == c0) return 16'h0;
    return c + 16'h1;
  endfunction

  function automatic logic next_act(logic a, logic oe, logic m0, logic m1);
    if (!oe) return 1'b0;
    if (m1) return 1'b0;
    if (m0) return 1'b1;
    return a;
  endfunction

  task automatic wr_ctrl(logic [7:0] v);
    @(negedge clk); ctrl_we = 1; ctrl_wd = v;
    @(negedge clk); ctrl_we = 0;
  endtask

  task automatic wr_cc(int ch, logic [15:0] v);
    @(negedge clk); cc_we = 2'b00; cc_we[ch] = 1'b1; cc_wd = v;
    @(negedge clk); cc_we = 0;
  endtask

  task automatic wr_run(logic v);
    @(negedge clk); run_we = 1; run_wd = v;
    @(negedge clk); run_we = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); eclr = 1;
    repeat (4) @(negedge clk);
    eclr = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic toggle_eclk(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); eclk = ~eclk;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] c0, c1, mc, snap;
    logic ma, oe, ah, cc;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", ctrl_rd, 8'h20);
    chk("R1 run", run_rd, 0);
    chk("R1 count", cnt, 0);
    chk("R1 flags", cflag, 0);
    chk("R1 pulse", pulse, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 pulse after release", pulse, 0);

    // R12 readback
    wr_ctrl(8'h5A); chk("R12 ctrl", ctrl_rd, 8'h5A);
    wr_cc(0, 16'h1234); chk("R12 cc0", cc0, 16'h1234);
    wr_cc(1, 16'hBEEF); chk("R12 cc1", cc1, 16'hBEEF);
    wr_run(1); chk("R12 run", run_rd, 1);

    // R9 external clear with ticking
    wr_ctrl(8'h27);
    tick = 1; repeat (10) @(negedge clk); tick = 0;
    chk("R9 counted", cnt, 10);
    pulse_clr();
    chk("R9 cleared", cnt, 0);
    tick = 1; repeat (3) @(negedge clk); tick = 0;
    chk("R9 resumes", cnt, 3);

    // R4 external clock source
    pulse_clr();
    wr_ctrl(8'h37); eedge = 2'b11; tick = 1;
    toggle_eclk(4); tick = 0;
    chk("R4 both edges, tick ignored", cnt, 4);
    eedge = 2'b01; toggle_eclk(4);
    chk("R4 rising only", cnt, 6);
    eedge = 2'b10; toggle_eclk(4);
    chk("R4 falling only", cnt, 8);
    eedge = 2'b00; toggle_eclk(2);
    chk("R4 none", cnt, 8);
    wr_ctrl(8'h27);
    tick = 1; repeat (2) @(negedge clk); tick = 0;
    chk("R4 internal tick", cnt, 10);

    // R8 compare clear
    pulse_clr(); wr_cc(0, 16'd4); wr_ctrl(8'h2F);
    tick = 1; repeat (5) @(negedge clk);
    chk("R8 cleared at match", cnt, 0);
    repeat (2) @(negedge clk); tick = 0;
    chk("R8 continues", cnt, 2);

    // R5/R6 directed: inactive after enable, set then reset, same-tick
    wr_ctrl(8'h27); pulse_clr(); wr_cc(0, 16'd3); wr_cc(1, 16'd6);
    wr_ctrl(8'h67);
    chk("R5 inactive after enable", pulse, 0);
    tick = 1; repeat (4) @(negedge clk); tick = 0;
    chk("R6 ch0 sets", pulse, 1);
    tick = 1; repeat (3) @(negedge clk); tick = 0;
    chk("R6 ch1 resets", pulse, 0);
    wr_ctrl(8'h27); pulse_clr(); wr_cc(0, 16'd2); wr_cc(1, 16'd2); wr_ctrl(8'h67);
    tick = 1; repeat (3) @(negedge clk); tick = 0;
    chk("R6 ch1 wins same tick", pulse, 0);
    // R5 disabled: match ignored
    wr_ctrl(8'h27); pulse_clr();
    tick = 1; repeat (3) @(negedge clk); tick = 0;
    chk("R5 disabled holds inactive", pulse, 0);

    // R7 active low
    wr_ctrl(8'h07); pulse_clr(); wr_cc(0, 16'd1); wr_cc(1, 16'd5); wr_ctrl(8'h47);
    chk("R7 inactive high", pulse, 1);
    tick = 1; repeat (2) @(negedge clk); tick = 0;
    chk("R7 active low", pulse, 0);

    // R11 capture mode freezes output
    wr_ctrl(8'h25); pulse_clr(); wr_ctrl(8'h65);
    tick = 1; repeat (3) @(negedge clk); tick = 0;
    chk("R11 frozen", pulse, 0);

    // R10 capture
    wr_ctrl(8'h24); pulse_clr();
    tick = 1; repeat (5) @(negedge clk);
    ctrig[0] = 1;
    repeat (2) @(negedge clk);
    snap = cnt;
    @(negedge clk);
    chk("R10 flag", cflag, 2'b01);
    chk("R10 value pre-increment", cc0, snap);
    chk("R10 count moved on", cnt, snap + 1);
    @(negedge clk);
    chk("R10 flag one cycle", cflag, 0);
    tick = 0; ctrig[0] = 0;
    repeat (4) @(negedge clk);
    chk("R10 channel 0 not recaptured", cc0, snap);

    // random: both compare, checked against model
    for (int s = 0; s < 12; s++) begin
      oe = $urandom % 2; ah = $urandom % 2; cc = $urandom % 2;
      c0 = $urandom % 24; c1 = $urandom % 24;
      wr_ctrl(8'h07); pulse_clr();
      wr_cc(0, c0); wr_cc(1, c1);
      wr_ctrl({1'b0, oe, ah, 1'b0, cc, 3'b011});
      mc = 0; ma = 0;
      for (int k = 0; k < 120; k++) begin
        logic t, m0, m1;
        chk("R6 random count", cnt, mc);
        chk("R6 random pulse", pulse, exp_pin(ah, ma));
        t = $urandom % 2; tick = t;
        m0 = t && mc == c0; m1 = t && mc == c1;
        ma = next_act(ma, oe, m0, m1);
        mc = next_cnt(mc, t, cc, c0);
        @(negedge clk);
      end
      tick = 0;
    end

    // R2 wrap, free running
    wr_ctrl(8'h27); pulse_clr();
    tick = 1; repeat (65535) @(negedge clk);
    chk("R2 at max", cnt, 16'hFFFF);
    @(negedge clk); chk("R2 wrapped", cnt, 0);
    @(negedge clk); tick = 0; chk("R2 keeps running", cnt, 1);

    // R3 overflow stop
    wr_ctrl(8'hA7); pulse_clr();
    tick = 1; repeat (65535) @(negedge clk);
    chk("R3 at max", cnt, 16'hFFFF);
    @(negedge clk); chk("R3 parked", cnt, 0);
    repeat (5) @(negedge clk);
    chk("R3 stays parked", cnt, 0);
    chk("R3 run bit kept", run_rd, 1);
    wr_run(1);
    chk("R3 restart write", cnt, 0);
    @(negedge clk); tick = 0;
    chk("R3 counting again", cnt, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule